// File: doc/BRIEF.md
# 16-bit Address Arithmetic Unit

This block performs the 16-bit arithmetic that a small 8-bit CPU applies to its register pairs, its stack pointer and its memory pointers. One operation is accepted per cycle when `op_valid` is high. The result, the address for the bus, and the next flag nibble appear registered one cycle later. The unit covers these operations:

- adding a register pair to HL;
- adding a signed 8-bit displacement to the stack pointer;
- plain 16-bit increment and decrement;
- the post-step of HL after an HL-indirect transfer;
- forming an address in the top 256-byte I/O page.

The surrounding core supplies the operands from its register file and writes `result` back to whichever register the instruction names. For example, the displacement add writes either SP or HL, and the unit does not need to know which. For the pointer-step forms, `addr` carries the pointer value used for the access and `result` carries the stepped pointer. The flag nibble is passed through unchanged by every operation that must not touch flags, so the core can always write `flags_out` back.

Top module: `addr_arith_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the registered outputs become zero: `res_valid`=0, `result`=0, `addr`=0, `flags_out`=0.
- R2: An operation presented with `op_valid`=1 shows its outputs after the next rising edge, with `res_valid`=1 for exactly that cycle. On a cycle with `op_valid`=0, `res_valid` drops and `result`, `addr` and `flags_out` keep their values.
- R3: Flag nibble layout on `flags_in` and `flags_out`: bit 3 is Z, bit 2 is N (subtract), bit 1 is H (half carry), bit 0 is C (carry).
- R4: Operation code 0 (pair add) gives `result` = `opnd_a` + `opnd_b` modulo 2^16 and `addr` = `opnd_a`.
- R5: For code 0, Z is copied from `flags_in` (even for a zero sum), N is 0, H is the carry out of bit 11, and C is the carry out of bit 15.
- R6: Code 1 (displacement add) sign-extends `imm8` to 16 bits and gives `result` = `opnd_a` + that value modulo 2^16, so bytes 0x80 to 0xFF subtract. `addr` = `opnd_a`.
- R7: For code 1, Z and N are forced to 0. H is the carry out of bit 3 and C is the carry out of bit 7 of the unsigned add of `opnd_a[7:0]` and the raw `imm8`.
- R8: Codes 2 (increment) and 3 (decrement) give `result` = `opnd_a` ± 1 with 16-bit wrap and `addr` = `opnd_a`. `flags_out` equals `flags_in`.
- R9: Codes 4 (pointer post-increment) and 5 (pointer post-decrement) give `addr` = `opnd_a` (the access address) and `result` = `opnd_a` ± 1 (the new pointer). Flags pass through unchanged.
- R10: Code 6 gives `addr` = `result` = 0xFF00 + `imm8`. Code 7 gives the same with `opnd_b[7:0]` in place of `imm8`. Flags pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_sel | input | 3 | Operation code (0..7, see requirements) |
| opnd_a | input | 16 | Base operand: HL, SP or the pair being stepped |
| opnd_b | input | 16 | Second operand: pair to add, or C in bits 7:0 |
| imm8 | input | 8 | Immediate byte: displacement or page offset |
| flags_in | input | 4 | Current flags {Z,N,H,C} |
| res_valid | output | 1 | Outputs below hold a new operation's result |
| result | output | 16 | Value to write back to the destination register |
| addr | output | 16 | Address for the bus access |
| flags_out | output | 4 | Next flags {Z,N,H,C} |

## Verification
The checker's properties assume that operands, immediate and flags are known whenever `op_valid` is high. They also assume that each operation is judged one cycle later against the inputs sampled with it. No ordering constraint between operations is needed, because every code is legal and each operation is independent. The stimulus changes inputs only on falling edges and pulses `op_valid` per operation. It also alters operands during idle cycles, so the hold behaviour is checked against inputs that really moved. The vector table exercises carries at bits 3, 7, 11 and 15, negative displacements and zero results that must not set Z.

// File: rtl/aau_pkg.sv
package aau_pkg;

    localparam int unsigned AAU_W     = 16;
    localparam int unsigned AAU_IMM_W = 8;

    typedef enum logic [2:0] {
        AOP_PAIR_ADD = 3'd0,
        AOP_DISP_ADD = 3'd1,
        AOP_INC      = 3'd2,
        AOP_DEC      = 3'd3,
        AOP_PTR_INC  = 3'd4,
        AOP_PTR_DEC  = 3'd5,
        AOP_PAGE_IMM = 3'd6,
        AOP_PAGE_REG = 3'd7
    } aau_op_e;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } aau_flags_t;

    function automatic logic is_step_op(aau_op_e op);
        return (op == AOP_INC) || (op == AOP_DEC) ||
               (op == AOP_PTR_INC) || (op == AOP_PTR_DEC);
    endfunction

    function automatic logic is_down_op(aau_op_e op);
        return (op == AOP_DEC) || (op == AOP_PTR_DEC);
    endfunction

endpackage

// File: rtl/aau_pair_add.sv
module aau_pair_add #(
    parameter int unsigned W        = 16,
    parameter int unsigned HALF_BIT = 11
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum,
    output logic         half_c,
    output logic         full_c
);
    localparam int unsigned LOW_W = HALF_BIT + 1;

    logic [W:0]     wide;
    logic [LOW_W:0] low;

    always_comb begin
        wide   = {1'b0, a} + {1'b0, b};
        low    = {1'b0, a[LOW_W-1:0]} + {1'b0, b[LOW_W-1:0]};
        sum    = wide[W-1:0];
        full_c = wide[W];
        half_c = low[LOW_W];
    end
endmodule

// File: rtl/aau_disp_add.sv
module aau_disp_add #(
    parameter int unsigned W     = 16,
    parameter int unsigned IMM_W = 8
) (
    input  logic [W-1:0]     base,
    input  logic [IMM_W-1:0] disp,
    output logic [W-1:0]     sum,
    output logic             half_c,
    output logic             byte_c
);
    localparam int unsigned NIB_W = IMM_W / 2;

    logic [W-1:0]     disp_ext;
    logic [IMM_W:0]   byte_sum;
    logic [NIB_W:0]   nib_sum;

    always_comb begin
        disp_ext = {{(W-IMM_W){disp[IMM_W-1]}}, disp};
        sum      = base + disp_ext;
        byte_sum = {1'b0, base[IMM_W-1:0]} + {1'b0, disp};
        nib_sum  = {1'b0, base[NIB_W-1:0]} + {1'b0, disp[NIB_W-1:0]};
        byte_c   = byte_sum[IMM_W];
        half_c   = nib_sum[NIB_W];
    end
endmodule

// File: rtl/aau_step.sv
module aau_step #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] base,
    input  logic         down,
    output logic [W-1:0] stepped
);
    always_comb begin
        if (down) stepped = base - W'(1);
        else      stepped = base + W'(1);
    end
endmodule

// File: rtl/aau_hipage.sv
module aau_hipage #(
    parameter int unsigned W     = 16,
    parameter int unsigned IMM_W = 8
) (
    input  logic [IMM_W-1:0] offset,
    output logic [W-1:0]     page_addr
);
    localparam logic [W-IMM_W-1:0] PAGE_HI = '1;

    assign page_addr = {PAGE_HI, offset};
endmodule

// File: rtl/addr_arith_unit.sv
module addr_arith_unit
    import aau_pkg::*;
#(
    parameter int unsigned W     = AAU_W,
    parameter int unsigned IMM_W = AAU_IMM_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             op_valid,
    input  logic [2:0]       op_sel,
    input  logic [W-1:0]     opnd_a,
    input  logic [W-1:0]     opnd_b,
    input  logic [IMM_W-1:0] imm8,
    input  logic [3:0]       flags_in,
    output logic             res_valid,
    output logic [W-1:0]     result,
    output logic [W-1:0]     addr,
    output logic [3:0]       flags_out
);
    localparam int unsigned HALF_BIT = W - 5;

    aau_op_e    op;
    aau_flags_t fl_in;
    aau_flags_t fl_nxt;
    logic [W-1:0] res_nxt;
    logic [W-1:0] addr_nxt;

    logic [W-1:0] pair_sum;
    logic         pair_h;
    logic         pair_c;
    logic [W-1:0] disp_sum;
    logic         disp_h;
    logic         disp_c;
    logic [W-1:0] step_val;
    logic [IMM_W-1:0] page_off;
    logic [W-1:0] page_val;

    assign op    = aau_op_e'(op_sel);
    assign fl_in = aau_flags_t'(flags_in);

    aau_pair_add #(.W(W), .HALF_BIT(HALF_BIT)) u_pair (
        .a      (opnd_a),
        .b      (opnd_b),
        .sum    (pair_sum),
        .half_c (pair_h),
        .full_c (pair_c)
    );

    aau_disp_add #(.W(W), .IMM_W(IMM_W)) u_disp (
        .base   (opnd_a),
        .disp   (imm8),
        .sum    (disp_sum),
        .half_c (disp_h),
        .byte_c (disp_c)
    );

    aau_step #(.W(W)) u_step (
        .base    (opnd_a),
        .down    (is_down_op(op)),
        .stepped (step_val)
    );

    assign page_off = (op == AOP_PAGE_REG) ? opnd_b[IMM_W-1:0] : imm8;

    aau_hipage #(.W(W), .IMM_W(IMM_W)) u_page (
        .offset    (page_off),
        .page_addr (page_val)
    );

    always_comb begin
        res_nxt  = opnd_a;
        addr_nxt = opnd_a;
        fl_nxt   = fl_in;
        unique case (op)
            AOP_PAIR_ADD: begin
                res_nxt  = pair_sum;
                fl_nxt.n = 1'b0;
                fl_nxt.h = pair_h;
                fl_nxt.c = pair_c;
            end
            AOP_DISP_ADD: begin
                res_nxt  = disp_sum;
                fl_nxt.z = 1'b0;
                fl_nxt.n = 1'b0;
                fl_nxt.h = disp_h;
                fl_nxt.c = disp_c;
            end
            AOP_PAGE_IMM, AOP_PAGE_REG: begin
                res_nxt  = page_val;
                addr_nxt = page_val;
            end
            default: begin
                if (is_step_op(op)) res_nxt = step_val;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            result    <= '0;
            addr      <= '0;
            flags_out <= '0;
        end else begin
            res_valid <= op_valid;
            if (op_valid) begin
                result    <= res_nxt;
                addr      <= addr_nxt;
                flags_out <= fl_nxt;
            end
        end
    end
endmodule

// File: rtl/addr_arith_unit_chk.sv
module addr_arith_unit_chk #(
    parameter int unsigned W     = 16,
    parameter int unsigned IMM_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             op_valid,
    input logic [2:0]       op_sel,
    input logic [W-1:0]     opnd_a,
    input logic [W-1:0]     opnd_b,
    input logic [IMM_W-1:0] imm8,
    input logic [3:0]       flags_in,
    input logic             res_valid,
    input logic [W-1:0]     result,
    input logic [W-1:0]     addr,
    input logic [3:0]       flags_out
);
    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (!res_valid && result == '0 && addr == '0 && flags_out == 4'h0));

    // R2
    valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> res_valid);

    // R2
    idle_holds_chk: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> (!res_valid && $stable(result) && $stable(addr) && $stable(flags_out)));

    // R5
    pair_keeps_z_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel == 3'd0) |=> (flags_out[3] == $past(flags_in[3]) && !flags_out[2]));

    // R7
    disp_clears_zn_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel == 3'd1) |=> (flags_out[3:2] == 2'b00));

    // R8
    step_flags_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (op_sel == 3'd2 || op_sel == 3'd3)) |=> (flags_out == $past(flags_in)));

    // R9
    ptr_post_step_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel == 3'd4) |=> (addr == $past(opnd_a) && result == $past(opnd_a) + W'(1)));

    // R10
    page_high_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel[2:1] == 2'b11) |=> (addr[W-1:IMM_W] == '1 && result == addr));
endmodule

bind addr_arith_unit addr_arith_unit_chk #(.W(W), .IMM_W(IMM_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .op_valid  (op_valid),
    .op_sel    (op_sel),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .imm8      (imm8),
    .flags_in  (flags_in),
    .res_valid (res_valid),
    .result    (result),
    .addr      (addr),
    .flags_out (flags_out)
);

// File: tb/addr_arith_unit_tb.sv
module addr_arith_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 16;

    typedef struct packed {
        logic [2:0]  op;
        logic [15:0] a;
        logic [15:0] b;
        logic [7:0]  imm;
        logic [3:0]  fin;
        logic [15:0] eres;
        logic [15:0] eaddr;
        logic [3:0]  ef;
    } vec_t;

    // flags {Z,N,H,C}
    localparam vec_t VECS [NVEC] = '{
        '{3'd0, 16'h0FFF, 16'h0001, 8'h00, 4'b1000, 16'h1000, 16'h0FFF, 4'b1010}, // R5 H from bit 11
        '{3'd0, 16'hFFFF, 16'h0001, 8'h00, 4'b0100, 16'h0000, 16'hFFFF, 4'b0011}, // R5 zero sum keeps Z=0
        '{3'd0, 16'h8000, 16'h8000, 8'h00, 4'b0000, 16'h0000, 16'h8000, 4'b0001}, // R4 C only
        '{3'd0, 16'h1234, 16'h1111, 8'h00, 4'b1111, 16'h2345, 16'h1234, 4'b1000}, // R4 no carry
        '{3'd1, 16'hFFF8, 16'h0000, 8'h08, 4'b1111, 16'h0000, 16'hFFF8, 4'b0011}, // R7 Z forced 0
        '{3'd1, 16'h1000, 16'h0000, 8'hFF, 4'b1100, 16'h0FFF, 16'h1000, 4'b0000}, // R6 minus one
        '{3'd1, 16'h0005, 16'h0000, 8'h80, 4'b0000, 16'hFF85, 16'h0005, 4'b0000}, // R6 minus 128
        '{3'd1, 16'h00FF, 16'h0000, 8'h01, 4'b0000, 16'h0100, 16'h00FF, 4'b0011}, // R7 byte carries
        '{3'd1, 16'h000F, 16'h0000, 8'hFE, 4'b0000, 16'h000D, 16'h000F, 4'b0011}, // R7 negative with carries
        '{3'd2, 16'hFFFF, 16'h0000, 8'h00, 4'b1010, 16'h0000, 16'hFFFF, 4'b1010}, // R8 wrap up
        '{3'd3, 16'h0000, 16'h0000, 8'h00, 4'b0101, 16'hFFFF, 16'h0000, 4'b0101}, // R8 wrap down
        '{3'd4, 16'hC0FF, 16'h0000, 8'h00, 4'b0000, 16'hC100, 16'hC0FF, 4'b0000}, // R9 post inc
        '{3'd5, 16'hC100, 16'h0000, 8'h00, 4'b1001, 16'hC0FF, 16'hC100, 4'b1001}, // R9 post dec
        '{3'd6, 16'h1234, 16'h5678, 8'h44, 4'b0110, 16'hFF44, 16'hFF44, 4'b0110}, // R10 imm page
        '{3'd7, 16'h1234, 16'hAB13, 8'h44, 4'b1001, 16'hFF13, 16'hFF13, 4'b1001}, // R10 reg page
        '{3'd3, 16'h0100, 16'h0000, 8'h00, 4'b0000, 16'h00FF, 16'h0100, 4'b0000}  // R8 borrow
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid;
    logic [2:0]  op_sel;
    logic [15:0] opnd_a;
    logic [15:0] opnd_b;
    logic [7:0]  imm8;
    logic [3:0]  flags_in;
    logic        res_valid;
    logic [15:0] result;
    logic [15:0] addr;
    logic [3:0]  flags_out;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    addr_arith_unit u_dut (
        .clk       (clk),
        .rst       (rst),
        .op_valid  (op_valid),
        .op_sel    (op_sel),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .imm8      (imm8),
        .flags_in  (flags_in),
        .res_valid (res_valid),
        .result    (result),
        .addr      (addr),
        .flags_out (flags_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        op_sel   = v.op;
        opnd_a   = v.a;
        opnd_b   = v.b;
        imm8     = v.imm;
        flags_in = v.fin;
        op_valid = 1'b1;
    endtask

    task automatic check_vec(input vec_t v, input int idx);
        string s;
        s = $sformatf("R2 vec%0d valid", idx);
        check(s, 32'(res_valid), 32'd1);
        s = $sformatf("R4/R6/R8/R9/R10 vec%0d result", idx);
        check(s, 32'(result), 32'(v.eres));
        s = $sformatf("R9/R10 vec%0d addr", idx);
        check(s, 32'(addr), 32'(v.eaddr));
        s = $sformatf("R3/R5/R7 vec%0d flags", idx);
        check(s, 32'(flags_out), 32'(v.ef));
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; op_valid = 1'b0; op_sel = 3'd0;
        opnd_a = 16'hAAAA; opnd_b = 16'h5555; imm8 = 8'h3C; flags_in = 4'hF;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 res_valid", 32'(res_valid), 32'd0);
        check("R1 result", 32'(result), 32'd0);
        check("R1 addr", 32'(addr), 32'd0);
        check("R1 flags", 32'(flags_out), 32'd0);
        rst = 1'b0;

        // table walk, one operation per pulse
        for (int i = 0; i < NVEC; i++) begin
            drive(VECS[i]);
            @(negedge clk);
            op_valid = 1'b0;
            check_vec(VECS[i], i);
        end

        // R2 hold while idle with moving inputs
        drive(VECS[0]);
        @(negedge clk);
        op_valid = 1'b0;
        opnd_a = 16'h7777; opnd_b = 16'h2222; imm8 = 8'h99; flags_in = 4'h0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R2 idle valid", 32'(res_valid), 32'd0);
            check("R2 idle result held", 32'(result), 32'h1000);
            check("R2 idle flags held", 32'(flags_out), 32'hA);
        end

        // R2 back-to-back operations
        drive(VECS[11]);
        @(negedge clk);
        check_vec(VECS[11], 11);
        drive(VECS[12]);
        @(negedge clk);
        check_vec(VECS[12], 12);
        drive(VECS[4]);
        @(negedge clk);
        op_valid = 1'b0;
        check_vec(VECS[4], 4);

        // R1 reset after activity
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset again result", 32'(result), 32'd0);
        check("R1 reset again flags", 32'(flags_out), 32'd0);
        rst = 1'b0;

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule